// File: doc/BRIEF.md
# Voltage-Drop Charge Termination Detector

This block decides when fast charging of a nickel cell should stop because the cell voltage has turned over. A scheduling block elsewhere pulses `sample_go` once per sample period. The detector then asks an external converter for a burst of readings of the single-cell voltage at a fixed spacing of `GAP_CYC` clocks. It sums the burst and shifts the sum down to form one averaged sample. The burst length is a power of two, so the average is a plain shift. Averaging over the whole window smooths out ripple from the mains supply.

Each averaged sample that lies strictly inside the valid voltage window is compared with the highest valid sample seen since the history was last cleared. Two modes set the drop that ends the charge. In negative-delta mode a large drop is needed. In peak mode a small drop is enough. The drop raises a sticky `term` output. A hold-off input keeps `term` low while the history still tracks the peak, so the spikes that follow the first application of charge current are ignored. A clear input erases the history.

Top module: `vt_term_det`

## Requirements
- R1: When `sample_go` is high and no burst is running, a burst starts. The burst issues exactly 16 single-cycle `conv_req` pulses when `mode` is 2'b10 (negative-delta) and exactly 32 when `mode` is 2'b00, 2'b01 or 2'b11 (peak). Consecutive pulses are `GAP_CYC` cycles apart. `mode` is sampled at the start of the burst, and `sample_go` during a running burst is ignored.
- R2: `rd_code` is accepted in every cycle of a burst in which `rd_vld` is high. One cycle after the last reading is accepted, `smp_done` pulses for one cycle and `smp_avg` holds the floor of the mean of the burst's readings.
- R3: A sample counts only if 1000 < `smp_avg` < 2000 (codes are 1 mV per LSB). A sample outside this window neither changes the history nor sets `term`.
- R4: The first in-window sample after reset or after a clear only loads the history and never sets `term`.
- R5: In negative-delta mode, `term` is set when the stored peak minus the sample is at least 12.
- R6: In peak mode, `term` is set when the stored peak minus the sample is at least 3. A drop of 2 or less does not set it.
- R7: The history is the maximum of all in-window samples since the last clear.
- R8: While `holdoff` is high in the cycle `smp_done` is high, the history still updates but `term` is not set.
- R9: `term` stays high until `hist_clr`. `hist_clr` clears both `term` and the history, and it wins over a sample that completes in the same cycle. That sample is then discarded.
- R10: After reset, `term`, `conv_req` and `smp_done` are low and no history is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Three-level mode select: 2'b10 negative-delta, others peak |
| sample_go | input | 1 | Starts one averaged sample |
| hist_clr | input | 1 | Erases the history and the termination flag |
| holdoff | input | 1 | Suppresses termination while the history keeps tracking |
| conv_req | output | 1 | One-cycle request for one converter reading |
| rd_vld | input | 1 | Reading on `rd_code` is valid |
| rd_code | input | ADC_W | Cell-voltage reading, 1 mV per LSB |
| smp_done | output | 1 | One-cycle pulse: averaged sample ready |
| smp_avg | output | ADC_W | Averaged sample value |
| term | output | 1 | Sticky voltage-termination flag |

## Verification
The bench walks the stored peak to exactly 2, 3, 11 and 12 codes above a new sample in each mode. A design that swapped the per-mode threshold, or that compared with `>` instead of `>=`, would stop early or late at these boundaries. It feeds samples exactly at 1000 and beyond 2000, and follows each with a sample that would only terminate if the out-of-window value had been taken into the history. It raises a new peak while hold-off is active, so a design that froze the history during hold-off misses the later 12-code drop. It also clears in the same cycle a sample completes, so a design that let the sample win would terminate on the next lower sample. The burst readings vary, which exposes a wrong shift or a wrong burst length as a wrong average.

// File: rtl/vt_pkg.sv
package vt_pkg;

    typedef enum logic [1:0] {
        TM_LOW  = 2'b00,
        TM_MID  = 2'b01,
        TM_HIGH = 2'b10,
        TM_RSV  = 2'b11
    } tm_sel_e;

    typedef struct packed {
        logic in_win;
        logic load;
        logic raise;
        logic fire;
    } verdict_t;

    function automatic logic is_ndv(input logic [1:0] m);
        return tm_sel_e'(m) == TM_HIGH;
    endfunction

endpackage

// File: rtl/vt_pacer.sv
module vt_pacer #(
    parameter int GAP_CYC = 7125,
    parameter int CNT_W   = 6,
    parameter int N_PK    = 32,
    parameter int N_ND    = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic nd_sel,
    output logic req
);
    localparam int GAP_W = $clog2(GAP_CYC + 1);
    localparam logic [CNT_W-1:0] LD_PK = CNT_W'(N_PK);
    localparam logic [CNT_W-1:0] LD_ND = CNT_W'(N_ND);
    localparam logic [GAP_W-1:0] GAP_RL = GAP_W'(GAP_CYC - 1);

    logic [CNT_W-1:0] left;
    logic [GAP_W-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
            gap  <= '0;
            req  <= 1'b0;
        end else begin
            req <= 1'b0;
            if (start) begin
                left <= nd_sel ? LD_ND : LD_PK;
                gap  <= '0;
            end else if (left != '0) begin
                if (gap == '0) begin
                    req  <= 1'b1;
                    left <= left - 1'b1;
                    gap  <= GAP_RL;
                end else begin
                    gap <= gap - 1'b1;
                end
            end
        end
    end

    AST_REQ_SPACED: assert property (@(posedge clk) disable iff (rst)
        (req && GAP_CYC > 1) |=> !req); // R1

endmodule

// File: rtl/vt_accum.sv
module vt_accum #(
    parameter int ADC_W  = 12,
    parameter int LOG_PK = 5,
    parameter int LOG_ND = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             nd_sel,
    input  logic             rd_vld,
    input  logic [ADC_W-1:0] rd_code,
    output logic             busy,
    output logic             done,
    output logic [ADC_W-1:0] avg
);
    localparam int CNT_W = LOG_PK + 1;
    localparam int ACC_W = ADC_W + LOG_PK;
    localparam logic [CNT_W-1:0] LAST_PK = CNT_W'((1 << LOG_PK) - 1);
    localparam logic [CNT_W-1:0] LAST_ND = CNT_W'((1 << LOG_ND) - 1);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum_nx;
    logic [CNT_W-1:0] rcv;
    logic [CNT_W-1:0] last;
    logic             nd_l;

    assign sum_nx = acc + ACC_W'(rd_code);
    assign last   = nd_l ? LAST_ND : LAST_PK;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            rcv  <= '0;
            nd_l <= 1'b0;
            busy <= 1'b0;
            done <= 1'b0;
            avg  <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                acc  <= '0;
                rcv  <= '0;
                nd_l <= nd_sel;
                busy <= 1'b1;
            end else if (busy && rd_vld) begin
                if (rcv == last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    avg  <= nd_l ? ADC_W'(sum_nx >> LOG_ND) : ADC_W'(sum_nx >> LOG_PK);
                end else begin
                    acc <= sum_nx;
                    rcv <= rcv + 1'b1;
                end
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R2
    AST_DONE_ENDS_BURST: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R2

endmodule

// File: rtl/vt_judge.sv
module vt_judge
    import vt_pkg::*;
#(
    parameter int ADC_W   = 12,
    parameter int WIN_LO  = 1000,
    parameter int WIN_HI  = 2000,
    parameter int DROP_PK = 3,
    parameter int DROP_ND = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    input  logic [ADC_W-1:0] avg,
    input  logic             nd_sel,
    input  logic             hist_clr,
    input  logic             holdoff,
    output logic             term
);
    localparam logic [ADC_W-1:0] LO = ADC_W'(WIN_LO);
    localparam logic [ADC_W-1:0] HI = ADC_W'(WIN_HI);
    localparam logic [ADC_W-1:0] TH_PK = ADC_W'(DROP_PK);
    localparam logic [ADC_W-1:0] TH_ND = ADC_W'(DROP_ND);

    logic [ADC_W-1:0] pk;
    logic             have;
    logic [ADC_W-1:0] diff;
    logic [ADC_W-1:0] thr;
    verdict_t         v;

    always_comb begin
        diff     = pk - avg;
        thr      = nd_sel ? TH_ND : TH_PK;
        v.in_win = done && (avg > LO) && (avg < HI);
        v.load   = v.in_win && !have;
        v.raise  = v.in_win && have && (avg > pk);
        v.fire   = v.in_win && have && !holdoff && (avg < pk) && (diff >= thr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pk   <= '0;
            have <= 1'b0;
            term <= 1'b0;
        end else if (hist_clr) begin
            pk   <= '0;
            have <= 1'b0;
            term <= 1'b0;
        end else begin
            if (v.load || v.raise) pk <= avg;
            if (v.load) have <= 1'b1;
            if (v.fire) term <= 1'b1;
        end
    end

    AST_CLR_WIPES: assert property (@(posedge clk) disable iff (rst)
        hist_clr |=> (!term && !have)); // R9
    AST_TERM_STICKY: assert property (@(posedge clk) disable iff (rst)
        (term && !hist_clr) |=> term); // R9
    AST_HOLDOFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!term && holdoff) |=> !term); // R8
    AST_FIRE_IN_WIN: assert property (@(posedge clk) disable iff (rst)
        (!term && !hist_clr && !(done && avg > LO && avg < HI)) |=> !term); // R3
    AST_PEAK_MONO: assert property (@(posedge clk) disable iff (rst)
        (have && !hist_clr) |=> (have && pk >= $past(pk))); // R7
    AST_FIRST_LOADS: assert property (@(posedge clk) disable iff (rst)
        (!have && !term) |=> !term); // R4

endmodule

// File: rtl/vt_term_det.sv
module vt_term_det
    import vt_pkg::*;
#(
    parameter int ADC_W   = 12,
    parameter int GAP_CYC = 7125,
    parameter int LOG_PK  = 5,
    parameter int LOG_ND  = 4,
    parameter int WIN_LO  = 1000,
    parameter int WIN_HI  = 2000,
    parameter int DROP_PK = 3,
    parameter int DROP_ND = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             sample_go,
    input  logic             hist_clr,
    input  logic             holdoff,
    output logic             conv_req,
    input  logic             rd_vld,
    input  logic [ADC_W-1:0] rd_code,
    output logic             smp_done,
    output logic [ADC_W-1:0] smp_avg,
    output logic             term
);
    localparam int N_PK  = 1 << LOG_PK;
    localparam int N_ND  = 1 << LOG_ND;
    localparam int CNT_W = LOG_PK + 1;

    logic busy;
    logic start;
    logic nd_now;
    logic nd_q;

    assign nd_now = is_ndv(mode);
    assign start  = sample_go && !busy;

    always_ff @(posedge clk) begin
        if (rst)        nd_q <= 1'b0;
        else if (start) nd_q <= nd_now;
    end

    vt_pacer #(
        .GAP_CYC(GAP_CYC), .CNT_W(CNT_W), .N_PK(N_PK), .N_ND(N_ND)
    ) u_pacer (
        .clk(clk), .rst(rst), .start(start), .nd_sel(nd_now), .req(conv_req)
    );

    vt_accum #(
        .ADC_W(ADC_W), .LOG_PK(LOG_PK), .LOG_ND(LOG_ND)
    ) u_accum (
        .clk(clk), .rst(rst), .start(start), .nd_sel(nd_now),
        .rd_vld(rd_vld), .rd_code(rd_code),
        .busy(busy), .done(smp_done), .avg(smp_avg)
    );

    vt_judge #(
        .ADC_W(ADC_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
        .DROP_PK(DROP_PK), .DROP_ND(DROP_ND)
    ) u_judge (
        .clk(clk), .rst(rst), .done(smp_done), .avg(smp_avg), .nd_sel(nd_q),
        .hist_clr(hist_clr), .holdoff(holdoff), .term(term)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!term && !conv_req && !smp_done)); // R10

endmodule

// File: tb/sim_vt_term_det.sv
module sim_vt_term_det;
    localparam int GAP = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic        sample_go = 1'b0;
    logic        hist_clr = 1'b0;
    logic        holdoff = 1'b0;
    logic        conv_req;
    logic        rd_vld = 1'b0;
    logic [11:0] rd_code = '0;
    logic        smp_done;
    logic [11:0] smp_avg;
    logic        term;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int base_g = 0;
    int idx_g = 0;
    int req_cnt = 0;
    int last_req = 0;

    // behavioural reference state
    bit m_busy = 0, m_nd = 0, m_done = 0, m_have = 0, m_term = 0;
    int m_cnt = 0, m_n = 0, m_sum = 0, m_avg = 0, m_pk = 0;

    always #4 clk = ~clk;

    vt_term_det #(.GAP_CYC(GAP)) u0 (
        .clk(clk), .rst(rst), .mode(mode), .sample_go(sample_go),
        .hist_clr(hist_clr), .holdoff(holdoff), .conv_req(conv_req),
        .rd_vld(rd_vld), .rd_code(rd_code), .smp_done(smp_done),
        .smp_avg(smp_avg), .term(term)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_busy = 0; m_done = 0; m_have = 0; m_term = 0; m_pk = 0;
        end else begin
            if (hist_clr) begin
                m_have = 0; m_term = 0;
            end else if (m_done && m_avg > 1000 && m_avg < 2000) begin
                if (!m_have) begin
                    m_pk = m_avg; m_have = 1;
                end else begin
                    if (!holdoff && (m_pk - m_avg) >= (m_nd ? 12 : 3)) m_term = 1;
                    if (m_avg > m_pk) m_pk = m_avg;
                end
            end
            m_done = 0;
            if (!m_busy && sample_go) begin
                m_busy = 1; m_cnt = 0; m_sum = 0;
                m_nd = (mode == 2'b10);
                m_n = m_nd ? 16 : 32;
            end else if (m_busy && rd_vld) begin
                m_sum += int'(rd_code);
                m_cnt++;
                if (m_cnt == m_n) begin
                    m_busy = 0; m_done = 1; m_avg = m_sum / m_n;
                end
            end
        end
    end

    // converter stand-in and per-cycle comparison
    always @(negedge clk) begin
        if (!rst) begin
            chk(smp_done == m_done, "R2 smp_done", int'(smp_done), int'(m_done));
            if (m_done) chk(int'(smp_avg) == m_avg, "R2 smp_avg", int'(smp_avg), m_avg);
            chk(term == m_term, "R7 term model", int'(term), int'(m_term));
        end
        rd_vld = conv_req;
        if (conv_req) begin
            rd_code = 12'(base_g + (idx_g & 3));
            idx_g++;
            req_cnt++;
            if (req_cnt > 1) chk(cyc - last_req == GAP, "R1 spacing", cyc - last_req, GAP);
            last_req = cyc;
        end
    end

    task automatic run_sample(input logic [1:0] m, input int base, input bit ho,
                              input bit extra_go, input bit clr_done);
        bit seen = 0;
        @(negedge clk);
        mode = m; holdoff = ho; base_g = base; idx_g = 0; req_cnt = 0;
        sample_go = 1'b1;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            sample_go = extra_go && (k == 10);
            if (k == 5) mode = ~m;
            if (smp_done) begin
                seen = 1;
                break;
            end
        end
        chk(seen, "R2 burst finished", int'(seen), 1);
        if (clr_done) hist_clr = 1'b1;
        @(negedge clk);
        hist_clr = 1'b0;
        chk(req_cnt == ((m == 2'b10) ? 16 : 32), "R1 request count", req_cnt,
            (m == 2'b10) ? 16 : 32);
        holdoff = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_term(input bit exp, input string tag);
        chk(term == exp, tag, int'(term), int'(exp));
    endtask

    task automatic pulse_clear();
        @(negedge clk); hist_clr = 1'b1;
        @(negedge clk); hist_clr = 1'b0;
        expect_term(0, "R9 clear drops term");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!term && !conv_req && !smp_done, "R10 reset outputs",
            int'({term, conv_req, smp_done}), 0);
        rst = 1'b0;
        @(negedge clk);

        // peak mode, averages are base+1
        run_sample(2'b00, 1500, 0, 0, 0); expect_term(0, "R4 first sample loads");
        run_sample(2'b01, 1510, 0, 1, 0); expect_term(0, "R1 mid mode, extra go ignored");
        run_sample(2'b00, 1509, 0, 0, 0); expect_term(0, "R6 drop 1");
        run_sample(2'b11, 1508, 0, 0, 0); expect_term(0, "R6 drop 2");
        run_sample(2'b00, 1507, 0, 0, 0); expect_term(1, "R6 drop 3 fires");
        run_sample(2'b00, 1600, 0, 0, 0); expect_term(1, "R9 term sticky");
        pulse_clear();

        // negative-delta mode
        run_sample(2'b10, 1800, 0, 0, 0); expect_term(0, "R4 load in negative-delta");
        run_sample(2'b10, 1700, 1, 0, 0); expect_term(0, "R8 holdoff blocks large drop");
        run_sample(2'b10, 1900, 1, 0, 0); expect_term(0, "R8 holdoff raises peak");
        run_sample(2'b10, 1890, 0, 0, 0); expect_term(0, "R5 drop 10");
        run_sample(2'b10, 1889, 0, 0, 0); expect_term(0, "R5 drop 11");
        run_sample(2'b10, 1888, 0, 0, 0); expect_term(1, "R5 drop 12 fires");
        pulse_clear();

        // voltage window
        run_sample(2'b00, 2500, 0, 0, 0); expect_term(0, "R3 above window");
        run_sample(2'b00, 1500, 0, 0, 0); expect_term(0, "R3 high sample not in history");
        run_sample(2'b00, 998, 0, 0, 0);  expect_term(0, "R3 below window");
        run_sample(2'b00, 999, 0, 0, 0);  expect_term(0, "R3 exactly 1000 excluded");
        run_sample(2'b00, 1498, 0, 0, 0); expect_term(0, "R7 peak kept over low samples");
        run_sample(2'b00, 1497, 0, 0, 0); expect_term(1, "R6 fires against 1501");
        pulse_clear();

        // clear wins over a completing sample
        run_sample(2'b00, 1600, 0, 0, 1); expect_term(0, "R9 clear at done");
        run_sample(2'b00, 1500, 0, 0, 0); expect_term(0, "R9 discarded sample not peak");
        run_sample(2'b00, 1497, 0, 0, 0); expect_term(1, "R6 fires after clear race");

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule